// File: doc/BRIEF.md
# Conflict-Free Banked Sample Store for a Radix-4 Transform

This block holds the N complex samples of a radix-4 transform in sixteen equal single-port banks. Samples arrive one per cycle on a serial load port and are placed at consecutive addresses. A radix-4 butterfly then names itself by a stage mode, a group and a butterfly index. In a single cycle the store returns that butterfly's four operands on a four-lane read bus. The butterfly's four results, presented on a four-lane write bus, go back to the same four locations and overwrite the operands in place.

Two address patterns are supported. In the wide pattern, used by the first stage, the four operands lie a quarter of the store apart. In the grouped pattern, used by the second stage, each quarter of the store is its own group, and the operands lie one sixteenth of the store apart inside that quarter. Addresses are spread over the banks so that, in both patterns, the four operands of any butterfly always sit in four different banks.

Top module: `fftmem_top`

## Requirements
- R1: After reset every lane of `rdData` is zero and the load position is address 0.
- R2: Each cycle with `loadValid` high stores `loadData` at the next address, starting at 0 and counting up by one. After address N-1 it returns to 0.
- R3: With `stageSel`=0 and `rdEn`=1, lane k of `rdData` returns address `bflyIdx + k*N/4` one cycle later, for k = 0..3.
- R4: With `stageSel`=1 and `rdEn`=1, lane k of `rdData` returns address `grp*N/4 + (bflyIdx mod N/16) + k*N/16` one cycle later.
- R5: With `wrEn`=1, lane k of `wrData` (bits k*SW upward) is stored at the same address that lane k would read under the current mode, group and index.
- R6: When `rdEn` and `wrEn` are both high in one cycle, the read returns the contents from before that cycle's write. The new contents are visible to later reads.
- R7: A cycle with `loadValid` high performs only the load. Any `rdEn` or `wrEn` in that cycle has no effect: `rdData` holds and no butterfly location changes.
- R8: In a cycle without a read, `rdData` holds its previous value.
- R9: The bank of an address is its top four bits, and the row is the remaining low bits. The four lanes of any butterfly use four distinct banks in both modes.
- R10: `grp` has no effect in mode 0. The bits of `bflyIdx` above the low log2(N/16) bits have no effect in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Serial load strobe |
| loadData | input | SW | Sample to load; real part in the upper half |
| stageSel | input | 1 | 0 = wide (first-stage) pattern, 1 = grouped (second-stage) pattern |
| grp | input | 2 | Quarter used in the grouped pattern |
| bflyIdx | input | log2(N)-2 | Butterfly index |
| rdEn | input | 1 | Read the butterfly's four operands |
| rdData | output | 4*SW | Four operands; lane k in bits k*SW upward |
| wrEn | input | 1 | Write the butterfly's four results |
| wrData | input | 4*SW | Four results; lane k in bits k*SW upward |

## Verification
Read data appears exactly one clock edge after the cycle that requests it. A load or a write becomes visible to a read requested in any later cycle, while a read in the same cycle as a write sees the old value. Inputs are driven at the falling edge. A behavioural model updates an address-indexed array and the expected lanes at each rising edge, so every falling-edge comparison checks the data that edge was due to produce. Full sweeps of both modes over uniquely valued samples show any bank collision or wrong lane mapping as a data mismatch.

// File: rtl/fftmem_pkg.sv
package fftmem_pkg;
  localparam int LANES = 4;
  localparam int BANKS = 16;
  localparam int BANK_W = 4;

  typedef enum logic { STAGE_WIDE = 1'b0, STAGE_GROUP = 1'b1 } stageMode_e;

  typedef struct packed {
    logic doLoad;
    logic doRead;
    logic doWrite;
  } memStrobe_t;
endpackage

// File: rtl/fftmem_ctrl.sv
module fftmem_ctrl
  import fftmem_pkg::*;
#(
  parameter int N = 256,
  localparam int AW = $clog2(N),
  localparam int IW = AW - 2,
  localparam int RW = AW - 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           loadValid,
  input  logic                           stageSel,
  input  logic [1:0]                     grp,
  input  logic [IW-1:0]                  bflyIdx,
  input  logic                           rdEn,
  input  logic                           wrEn,
  output memStrobe_t                     strobe,
  output logic [LANES-1:0][BANK_W-1:0]   laneBank,
  output logic [LANES-1:0][RW-1:0]       laneRow,
  output logic [BANK_W-1:0]              loadBank,
  output logic [RW-1:0]                  loadRow
);
  localparam int QUARTER   = N / 4;
  localparam int SIXTEENTH = N / 16;

  logic [AW-1:0] loadPtr;
  logic [AW-1:0] laneAddr [LANES];
  stageMode_e    mode;

  assign mode = stageMode_e'(stageSel);

  always_ff @(posedge clk) begin
    if (!rstN)          loadPtr <= '0;
    else if (loadValid) loadPtr <= loadPtr + AW'(1);
  end

  assign loadBank = loadPtr[AW-1 -: BANK_W];
  assign loadRow  = loadPtr[RW-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (mode == STAGE_WIDE)
        laneAddr[k] = AW'(bflyIdx) + AW'(k * QUARTER);
      else
        laneAddr[k] = AW'(grp) * AW'(QUARTER) + AW'(bflyIdx[RW-1:0])
                    + AW'(k * SIXTEENTH);
    end
    assign laneBank[k] = laneAddr[k][AW-1 -: BANK_W];
    assign laneRow[k]  = laneAddr[k][RW-1:0];
  end

  assign strobe.doLoad  = loadValid;
  assign strobe.doRead  = rdEn & ~loadValid;
  assign strobe.doWrite = wrEn & ~loadValid;
endmodule

// File: rtl/fftmem_banks.sv
module fftmem_banks
  import fftmem_pkg::*;
#(
  parameter int RW = 4,
  parameter int SW = 32,
  localparam int ROWS = 1 << RW
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  memStrobe_t                     strobe,
  input  logic [LANES-1:0][BANK_W-1:0]   laneBank,
  input  logic [LANES-1:0][RW-1:0]       laneRow,
  input  logic [BANK_W-1:0]              loadBank,
  input  logic [RW-1:0]                  loadRow,
  input  logic [SW-1:0]                  loadData,
  input  logic [LANES-1:0][SW-1:0]       wrLanes,
  output logic [LANES-1:0][SW-1:0]       rdLanes
);
  logic [SW-1:0]     bankQ   [BANKS];
  logic [BANK_W-1:0] laneSelQ [LANES];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [SW-1:0] store [ROWS];
    logic          hit, rdHit, wrHit;
    logic [RW-1:0] row;
    logic [SW-1:0] wd;

    always_comb begin
      hit = 1'b0;
      row = '0;
      wd  = '0;
      if (strobe.doLoad) begin
        if (loadBank == BANK_W'(b)) begin
          hit = 1'b1;
          row = loadRow;
          wd  = loadData;
        end
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (laneBank[k] == BANK_W'(b)) begin
            hit = 1'b1;
            row = laneRow[k];
            wd  = wrLanes[k];
          end
        end
      end
      rdHit = hit & strobe.doRead;
      wrHit = hit & (strobe.doWrite | strobe.doLoad);
    end

    always_ff @(posedge clk) begin
      if (wrHit) store[row] <= wd;
    end

    always_ff @(posedge clk) begin
      if (!rstN)      bankQ[b] <= '0;
      else if (rdHit) bankQ[b] <= store[row];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN)              laneSelQ[k] <= '0;
      else if (strobe.doRead) laneSelQ[k] <= laneBank[k];
    end
    assign rdLanes[k] = bankQ[laneSelQ[k]];
  end
endmodule

// File: rtl/fftmem_top.sv
module fftmem_top
  import fftmem_pkg::*;
#(
  parameter int N = 256,
  parameter int SW = 32,
  localparam int AW = $clog2(N),
  localparam int IW = AW - 2,
  localparam int RW = AW - 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadValid,
  input  logic [SW-1:0]       loadData,
  input  logic                stageSel,
  input  logic [1:0]          grp,
  input  logic [IW-1:0]       bflyIdx,
  input  logic                rdEn,
  output logic [LANES*SW-1:0] rdData,
  input  logic                wrEn,
  input  logic [LANES*SW-1:0] wrData
);
  memStrobe_t                   strobe;
  logic [LANES-1:0][BANK_W-1:0] laneBank;
  logic [LANES-1:0][RW-1:0]     laneRow;
  logic [BANK_W-1:0]            loadBank;
  logic [RW-1:0]                loadRow;
  logic [LANES-1:0][SW-1:0]     wrLanes, rdLanes;

  assign wrLanes = wrData;
  assign rdData  = rdLanes;

  fftmem_ctrl #(.N(N)) ctrl_i (
    .clk, .rstN, .loadValid, .stageSel, .grp, .bflyIdx, .rdEn, .wrEn,
    .strobe, .laneBank, .laneRow, .loadBank, .loadRow
  );

  fftmem_banks #(.RW(RW), .SW(SW)) banks_i (
    .clk, .rstN, .strobe, .laneBank, .laneRow, .loadBank, .loadRow,
    .loadData, .wrLanes, .rdLanes
  );
endmodule

// File: rtl/fftmem_chk.sv
module fftmem_chk
  import fftmem_pkg::*;
#(
  parameter int RW = 4,
  parameter int SW = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         loadValid,
  input logic                         rdEn,
  input memStrobe_t                   strobe,
  input logic [LANES-1:0][BANK_W-1:0] laneBank,
  input logic [LANES-1:0][RW-1:0]     laneRow,
  input logic [BANK_W-1:0]            loadBank,
  input logic [RW-1:0]                loadRow,
  input logic [LANES*SW-1:0]          rdData
);
  logic [BANKS-1:0] bankMask;
  always_comb begin
    bankMask = '0;
    for (int k = 0; k < LANES; k++) bankMask |= BANKS'(1) << laneBank[k];
  end

  AST_LANE_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead || strobe.doWrite) |-> ($countones(bankMask) == LANES)); // R9

  AST_LANE_ROW_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (laneRow[0] == laneRow[1]) && (laneRow[1] == laneRow[2]) && (laneRow[2] == laneRow[3])); // R9

  AST_LOAD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> ({loadBank, loadRow} == $past({loadBank, loadRow}) + 1'b1)); // R2

  AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |=> $stable(rdData)); // R8

  AST_RD_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> $stable(rdData)); // R7
endmodule

bind fftmem_top fftmem_chk #(.RW(RW), .SW(SW)) chk_i (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .rdEn(rdEn), .strobe(strobe),
  .laneBank(laneBank), .laneRow(laneRow), .loadBank(loadBank), .loadRow(loadRow),
  .rdData(rdData)
);

// File: tb/fftmem_top_tb_top.sv
`timescale 1ns/1ps
module fftmem_top_tb_top;
  localparam int N  = 256;
  localparam int SW = 32;
  localparam int AW = $clog2(N);
  localparam int IW = AW - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic [SW-1:0] loadData = '0;
  logic stageSel = 1'b0;
  logic [1:0] grp = '0;
  logic [IW-1:0] bflyIdx = '0;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [4*SW-1:0] wrData = '0;
  logic [4*SW-1:0] rdData;

  always #5 clk = ~clk;

  fftmem_top #(.N(N), .SW(SW)) dut_i (
    .clk, .rstN, .loadValid, .loadData, .stageSel, .grp, .bflyIdx,
    .rdEn, .rdData, .wrEn, .wrData
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [SW-1:0] mdl [N];
  logic [SW-1:0] expRd [4];
  int ptr = 0;

  function automatic int laneAddr(bit md, int g, int b, int k);
    if (!md) return (b % (N/4)) + k*(N/4);
    return g*(N/4) + (b % (N/16)) + k*(N/16);
  endfunction

  function automatic logic [SW-1:0] sampleOf(int a);
    return {16'(a*3 + 1), ~16'(a)};
  endfunction

  // reference model, evaluated at each rising edge on inputs set at the falling edge
  always @(posedge clk) begin
    if (!rstN) begin
      ptr = 0;
      for (int k = 0; k < 4; k++) expRd[k] = '0;
    end else if (loadValid) begin
      mdl[ptr] = loadData;
      ptr = (ptr + 1) % N;
    end else begin
      if (rdEn)
        for (int k = 0; k < 4; k++) expRd[k] = mdl[laneAddr(stageSel, grp, bflyIdx, k)];
      if (wrEn)
        for (int k = 0; k < 4; k++) mdl[laneAddr(stageSel, grp, bflyIdx, k)] = wrData[k*SW +: SW];
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      for (int k = 0; k < 4; k++) begin
        checks++;
        if (rdData[k*SW +: SW] !== expRd[k]) begin
          errors++;
          $display("FAIL %s lane %0d: actual %h expected %h", curReq, k, rdData[k*SW +: SW], expRd[k]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(bit lv, logic [SW-1:0] ld, bit md, int g, int b, bit re, bit we,
                      logic [4*SW-1:0] wd);
    loadValid = lv; loadData = ld; stageSel = md; grp = 2'(g); bflyIdx = IW'(b);
    rdEn = re; wrEn = we; wrData = wd;
    @(negedge clk);
  endtask

  function automatic logic [4*SW-1:0] pattern(int base);
    logic [4*SW-1:0] v;
    for (int k = 0; k < 4; k++) v[k*SW +: SW] = SW'(base * 7919 + k * 32'h1111_0101);
    return v;
  endfunction

  initial begin
    @(negedge clk);
    curReq = "R1";
    repeat (3) step(0, '0, 0, 0, 0, 0, 0, '0);
    rstN = 1'b1;
    repeat (2) step(0, '0, 0, 0, 0, 0, 0, '0);

    curReq = "R2";
    for (int a = 0; a < N; a++) step(1, sampleOf(a), 0, 0, 0, 0, 0, '0);

    curReq = "R3";
    for (int b = 0; b < N/4; b++) step(0, '0, 0, 0, b, 1, 0, '0);

    curReq = "R4";
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < N/16; b++) step(0, '0, 1, g, b, 1, 0, '0);

    curReq = "R10";
    for (int b = 0; b < N/4; b += 3) step(0, '0, 0, (b * 5) % 4, b, 1, 0, '0);
    for (int b = 0; b < N/4; b += 5) step(0, '0, 1, b % 4, b, 1, 0, '0);

    curReq = "R8";
    for (int b = 0; b < 6; b++) step(0, '0, b % 2, b % 4, b * 9, 0, 0, '0);

    curReq = "R5";
    step(0, '0, 0, 0, 5, 0, 1, pattern(1));
    step(0, '0, 0, 0, 5, 1, 0, '0);
    step(0, '0, 1, 2, 3, 0, 1, pattern(2));
    step(0, '0, 1, 2, 3, 1, 0, '0);
    step(0, '0, 0, 0, 35, 1, 0, '0);

    curReq = "R6";
    step(0, '0, 0, 1, 7, 1, 1, pattern(3));
    step(0, '0, 0, 1, 7, 1, 0, '0);
    step(0, '0, 1, 3, 14, 1, 1, pattern(4));
    step(0, '0, 1, 3, 14, 1, 0, '0);

    curReq = "R7";
    step(0, '0, 0, 0, 9, 1, 0, '0);
    step(1, 32'hCAFE_F00D, 0, 0, 9, 1, 1, pattern(5));
    step(0, '0, 0, 0, 9, 1, 0, '0);
    curReq = "R2";
    step(0, '0, 0, 0, 0, 1, 0, '0);

    curReq = "R9";
    for (int a = 0; a < N; a++) step(1, sampleOf(a + 1000), 0, 0, 0, 0, 0, '0);
    for (int b = 0; b < N/4; b++) step(0, '0, 0, 0, b, 1, 0, '0);
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < N/16; b++) step(0, '0, 1, g, b, 1, 0, '0);

    step(0, '0, 0, 0, 0, 0, 0, '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule